// File: doc/BRIEF.md
# Byte-Lane Asynchronous SRAM Controller

This block sits between a synchronous host port and an external asynchronous static RAM with a 16-bit data bus split into two byte lanes. A host request carries an address, write data, a two-bit lane mask and a direction flag. The controller turns each request into a write-enable-strobed write or an output-enable read on the memory pins. It returns a one-cycle completion pulse, and for reads it also returns the captured data.

The memory is selected through a pair of chip enables of opposite polarity. Between requests both enables are held inactive, so the part powers down and every data lane floats. Write and read phases have run-time cycle counts. A write has a setup phase, a strobe phase and a hold phase. A read has an access phase. A phase programmed with count N lasts N+1 clock cycles. The data bus is described as a driven output with a per-lane drive-enable and a separate input, so the pad ring can form the tristate.

Top module: `sram_lane_ctrl`

## Requirements
- R1: After reset, mem_ce_n=1, mem_ce=0, mem_oe_n=1, mem_we_n=1, mem_lb_n=1, mem_ub_n=1, mem_dq_oe=0, req_ready=1 and rsp_valid=0.
- R2: A request is taken on a rising edge where req_valid and req_ready are both 1. req_ready is 0 from the next cycle until the cycle after the completion pulse. rsp_valid is high for exactly one cycle per request.
- R3: A write with a nonzero mask runs three phases, all with both chip enables active and mem_oe_n=1. The setup phase lasts cfg_setup+1 cycles with mem_we_n=1. The strobe phase lasts cfg_pulse+1 cycles with mem_we_n=0. The hold phase lasts cfg_hold+1 cycles with mem_we_n=1. The completion cycle follows, and in it both chip enables are released together.
- R4: While a memory cycle runs, mem_lb_n equals the inverse of mask bit 0 (lane bits 7:0) and mem_ub_n equals the inverse of mask bit 1 (lane bits 15:8).
- R5: mem_dq_oe bit 0 covers bits 7:0 and bit 1 covers bits 15:8. A lane is driven only in the strobe and hold phases of a write, and only when its mask bit is set. There it carries the request's write data. No lane is driven while mem_oe_n is 0. A lane only starts driving after mem_oe_n has been 1 in the previous cycle.
- R6: A read with a nonzero mask keeps both chip enables active, mem_oe_n=0 and mem_we_n=1 for cfg_access+1 cycles, and the completion cycle follows.
- R7: A request with mask 0 touches no memory pin. Its completion pulse comes in the first cycle after it is taken, and rsp_rdata is 0.
- R8: mem_addr holds the request address, unchanged, for as long as the chip enables stay active.
- R9: Whenever req_ready is 1, the memory is deselected and no data lane is driven.
- R10: For a read, rsp_rdata in the completion cycle holds the bus value sampled in the last access cycle on enabled lanes and 0 on masked lanes. For a write, rsp_rdata is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | 16 | Write data |
| req_mask | input | 2 | Lane mask, bit 0 = bits 7:0, bit 1 = bits 15:8 |
| cfg_setup | input | CNT_W | Write setup count |
| cfg_pulse | input | CNT_W | Write strobe count |
| cfg_hold | input | CNT_W | Write hold count |
| cfg_access | input | CNT_W | Read access count |
| rsp_valid | output | 1 | Completion pulse |
| rsp_rdata | output | 16 | Read data, masked lanes zero |
| mem_addr | output | ADDR_W | Memory address |
| mem_ce_n | output | 1 | Active-low chip enable |
| mem_ce | output | 1 | Active-high chip enable |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_lb_n | output | 1 | Lower lane enable, active low |
| mem_ub_n | output | 1 | Upper lane enable, active low |
| mem_dq_out | output | 16 | Data driven toward memory |
| mem_dq_oe | output | 2 | Per-lane drive enable |
| mem_dq_in | input | 16 | Data sampled from memory |

## Verification
The checks assume two things about the inputs. The cfg counts stay constant while a request is in flight. mem_dq_in only carries memory data while the controller has the part selected with mem_oe_n low on that lane. The bench changes the cfg counts only between requests, when req_ready is high. Its memory model drives a fixed junk pattern on every lane it is not asked to drive, so a missing lane mask shows up as a wrong read value rather than being hidden by a zero.

// File: rtl/sram_lane_pkg.sv
package sram_lane_pkg;
  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_WSETUP = 3'd1,
    ST_WPULSE = 3'd2,
    ST_WHOLD  = 3'd3,
    ST_RACC   = 3'd4,
    ST_DONE   = 3'd5
  } phase_t;

  function automatic logic phase_selects(input phase_t p);
    return (p == ST_WSETUP) || (p == ST_WPULSE) || (p == ST_WHOLD) || (p == ST_RACC);
  endfunction

  function automatic logic phase_drives(input phase_t p);
    return (p == ST_WPULSE) || (p == ST_WHOLD);
  endfunction
endpackage

// File: rtl/sram_lane_timer.sv
module sram_lane_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)               cnt_d = load_val;
    else if (cnt_q != '0)   cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign expired = (cnt_q == '0);

  AST_TMR_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cnt_q) == '0 && !$past(load)) |-> cnt_q == '0); // R3
endmodule

// File: rtl/sram_lane_fsm.sv
module sram_lane_fsm
  import sram_lane_pkg::*;
#(
  parameter int LANES = 2,
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic [LANES-1:0] req_mask,
  input  logic [CNT_W-1:0] cfg_setup,
  input  logic [CNT_W-1:0] cfg_pulse,
  input  logic [CNT_W-1:0] cfg_hold,
  input  logic [CNT_W-1:0] cfg_access,
  input  logic             tmr_expired,
  output logic             tmr_load,
  output logic [CNT_W-1:0] tmr_val,
  output phase_t           phase_q,
  output phase_t           phase_d,
  output logic             accept,
  output logic             sel_q,
  output logic             rd_en_q,
  output logic             wr_en_q
);
  assign accept = (phase_q == ST_IDLE) && req_valid;

  always_comb begin
    phase_d  = phase_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    case (phase_q)
      ST_IDLE: if (req_valid) begin
        if (req_mask == '0) phase_d = ST_DONE;
        else if (req_write) begin
          phase_d = ST_WSETUP; tmr_load = 1'b1; tmr_val = cfg_setup;
        end else begin
          phase_d = ST_RACC;   tmr_load = 1'b1; tmr_val = cfg_access;
        end
      end
      ST_WSETUP: if (tmr_expired) begin
        phase_d = ST_WPULSE; tmr_load = 1'b1; tmr_val = cfg_pulse;
      end
      ST_WPULSE: if (tmr_expired) begin
        phase_d = ST_WHOLD;  tmr_load = 1'b1; tmr_val = cfg_hold;
      end
      ST_WHOLD:  if (tmr_expired) phase_d = ST_DONE;
      ST_RACC:   if (tmr_expired) phase_d = ST_DONE;
      default:   phase_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= ST_IDLE;
      sel_q   <= 1'b0;
      rd_en_q <= 1'b0;
      wr_en_q <= 1'b0;
    end else begin
      phase_q <= phase_d;
      sel_q   <= phase_selects(phase_d);
      rd_en_q <= (phase_d == ST_RACC);
      wr_en_q <= (phase_d == ST_WPULSE);
    end
  end

  AST_RD_WR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_en_q && wr_en_q)); // R6
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == ST_DONE) |=> (phase_q == ST_IDLE)); // R2
endmodule

// File: rtl/sram_lane_datapath.sv
module sram_lane_datapath
  import sram_lane_pkg::*;
#(
  parameter int ADDR_W = 18,
  parameter int LANES  = 2,
  parameter int LANE_W = 8,
  localparam int DATA_W = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              capture,
  input  phase_t            phase_d,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [LANES-1:0]  req_mask,
  input  logic [DATA_W-1:0] dq_in,
  output logic [ADDR_W-1:0] addr_q,
  output logic [DATA_W-1:0] wdata_q,
  output logic [LANES-1:0]  lane_en_q,
  output logic [LANES-1:0]  dq_oe_q,
  output logic [DATA_W-1:0] rdata_q
);
  logic [LANES-1:0] mask_q;
  logic [LANES-1:0] mask_next;

  assign mask_next = accept ? req_mask : mask_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
      mask_q  <= '0;
    end else if (accept) begin
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
      mask_q  <= req_mask;
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] lane_rd_d;

    always_comb begin
      lane_rd_d = rdata_q[g*LANE_W +: LANE_W];
      if (accept)       lane_rd_d = '0;
      else if (capture) lane_rd_d = mask_q[g] ? dq_in[g*LANE_W +: LANE_W] : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        lane_en_q[g]                 <= 1'b0;
        dq_oe_q[g]                   <= 1'b0;
        rdata_q[g*LANE_W +: LANE_W]  <= '0;
      end else begin
        lane_en_q[g]                 <= phase_selects(phase_d) && mask_next[g];
        dq_oe_q[g]                   <= phase_drives(phase_d) && mask_next[g];
        rdata_q[g*LANE_W +: LANE_W]  <= lane_rd_d;
      end
    end

    AST_LANE_DRIVE_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
      dq_oe_q[g] |-> lane_en_q[g]); // R4
  end
endmodule

// File: rtl/sram_lane_ctrl.sv
module sram_lane_ctrl
  import sram_lane_pkg::*;
#(
  parameter int ADDR_W = 18,
  parameter int CNT_W  = 4,
  parameter int LANES  = 2,
  parameter int LANE_W = 8,
  localparam int DATA_W = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [LANES-1:0]  req_mask,
  input  logic [CNT_W-1:0]  cfg_setup,
  input  logic [CNT_W-1:0]  cfg_pulse,
  input  logic [CNT_W-1:0]  cfg_hold,
  input  logic [CNT_W-1:0]  cfg_access,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_ce_n,
  output logic              mem_ce,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic              mem_lb_n,
  output logic              mem_ub_n,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic [LANES-1:0]  mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_in
);
  phase_t           phase_q, phase_d;
  logic             accept, tmr_load, tmr_expired;
  logic [CNT_W-1:0] tmr_val;
  logic             sel_q, rd_en_q, wr_en_q;
  logic [LANES-1:0] lane_en_q;

  sram_lane_fsm #(.LANES(LANES), .CNT_W(CNT_W)) u_fsm (
    .clk, .rst_n, .req_valid, .req_write, .req_mask,
    .cfg_setup, .cfg_pulse, .cfg_hold, .cfg_access,
    .tmr_expired, .tmr_load, .tmr_val,
    .phase_q, .phase_d, .accept, .sel_q, .rd_en_q, .wr_en_q
  );

  sram_lane_timer #(.CNT_W(CNT_W)) u_timer (
    .clk, .rst_n, .load(tmr_load), .load_val(tmr_val), .expired(tmr_expired)
  );

  sram_lane_datapath #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_dp (
    .clk, .rst_n, .accept,
    .capture(phase_q == ST_RACC && tmr_expired),
    .phase_d, .req_addr, .req_wdata, .req_mask, .dq_in(mem_dq_in),
    .addr_q(mem_addr), .wdata_q(mem_dq_out), .lane_en_q,
    .dq_oe_q(mem_dq_oe), .rdata_q(rsp_rdata)
  );

  assign req_ready = (phase_q == ST_IDLE);
  assign rsp_valid = (phase_q == ST_DONE);
  assign mem_ce_n  = !sel_q;
  assign mem_ce    = sel_q;
  assign mem_oe_n  = !rd_en_q;
  assign mem_we_n  = !wr_en_q;
  assign mem_lb_n  = !lane_en_q[0];
  assign mem_ub_n  = !lane_en_q[LANES-1];

  AST_NO_CONTENTION: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_dq_oe != '0) |-> mem_oe_n); // R5
  AST_DRIVE_AFTER_OE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_dq_oe != '0) |-> $past(mem_oe_n)); // R5
  AST_WE_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> (!mem_ce_n && mem_ce && mem_oe_n)); // R3
  AST_OE_WE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> (mem_we_n && !mem_ce_n)); // R6
  AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_ce && $past(mem_ce)) |-> $stable(mem_addr)); // R8
  AST_IDLE_FLOAT: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (mem_ce_n && !mem_ce && mem_dq_oe == '0)); // R9
  AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> (!rsp_valid && req_ready)); // R2
endmodule

// File: tb/sram_lane_ctrl_tb.sv
module sram_lane_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [17:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [1:0]  req_mask = '0;
  logic [3:0]  cfg_setup = '0, cfg_pulse = '0, cfg_hold = '0, cfg_access = '0;
  logic        req_ready, rsp_valid;
  logic [15:0] rsp_rdata, mem_dq_out, mem_dq_in;
  logic [17:0] mem_addr;
  logic        mem_ce_n, mem_ce, mem_oe_n, mem_we_n, mem_lb_n, mem_ub_n;
  logic [1:0]  mem_dq_oe;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;
  logic [15:0] exp_q[$];
  logic [15:0] sram [16];
  logic [15:0] shadow [16];

  always #2 clk = ~clk;

  sram_lane_ctrl u_dut (
    .clk, .rst_n, .req_valid, .req_ready, .req_write, .req_addr, .req_wdata,
    .req_mask, .cfg_setup, .cfg_pulse, .cfg_hold, .cfg_access, .rsp_valid,
    .rsp_rdata, .mem_addr, .mem_ce_n, .mem_ce, .mem_oe_n, .mem_we_n,
    .mem_lb_n, .mem_ub_n, .mem_dq_out, .mem_dq_oe, .mem_dq_in
  );

  // memory model: undriven lanes carry junk so masking is visible
  wire sel = !mem_ce_n && mem_ce;
  assign mem_dq_in[7:0]  = (sel && !mem_oe_n && !mem_lb_n) ? sram[mem_addr[3:0]][7:0]  : 8'h5A;
  assign mem_dq_in[15:8] = (sel && !mem_oe_n && !mem_ub_n) ? sram[mem_addr[3:0]][15:8] : 8'hC3;

  always @(posedge mem_we_n) begin
    if (rst_n && sel) begin
      if (!mem_lb_n && mem_dq_oe[0]) sram[mem_addr[3:0]][7:0]  <= mem_dq_out[7:0];
      if (!mem_ub_n && mem_dq_oe[1]) sram[mem_addr[3:0]][15:8] <= mem_dq_out[15:8];
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (exp_q.size() == 0) chk(0, "R2 unexpected completion", 32'(rsp_rdata), 0);
      else begin
        logic [15:0] e;
        e = exp_q.pop_front();
        chk(rsp_rdata == e, "R10 response data", 32'(rsp_rdata), 32'(e));
      end
    end
  end

  function automatic logic [15:0] lmask(input logic [1:0] m);
    return {{8{m[1]}}, {8{m[0]}}};
  endfunction

  task automatic check_sel(input string tag, input logic [1:0] m, input logic [17:0] a);
    chk(!mem_ce_n && mem_ce, {tag, " chip enables"}, {mem_ce_n, mem_ce}, 2'b01);
    chk({mem_ub_n, mem_lb_n} == ~m, "R4 lane enables", {mem_ub_n, mem_lb_n}, ~m);
    chk(mem_addr == a, "R8 address held", mem_addr, a);
  endtask

  task automatic do_req(input bit wr, input logic [17:0] a, input logic [15:0] d, input logic [1:0] m);
    @(negedge clk);
    req_valid = 1; req_write = wr; req_addr = a; req_wdata = d; req_mask = m;
    while (!req_ready) @(negedge clk);
    exp_q.push_back(wr ? 16'h0 : (shadow[a[3:0]] & lmask(m)));
    @(negedge clk);
    req_valid = 0;
    chk(!req_ready, "R2 ready low after accept", req_ready, 0);
    if (m == 2'b00) begin
      chk(rsp_valid, "R7 immediate completion", rsp_valid, 1);
      chk(mem_ce_n && !mem_ce && mem_we_n && mem_oe_n, "R7 pins untouched",
          {mem_ce_n, mem_ce, mem_we_n, mem_oe_n}, 4'b1011);
    end else if (wr) begin
      for (int i = 0; i <= cfg_setup; i++) begin
        check_sel("R3 setup", m, a);
        chk(mem_we_n && mem_oe_n, "R3 setup strobes", {mem_we_n, mem_oe_n}, 2'b11);
        chk(mem_dq_oe == 2'b00, "R5 no drive in setup", mem_dq_oe, 0);
        @(negedge clk);
      end
      for (int i = 0; i <= cfg_pulse; i++) begin
        check_sel("R3 strobe", m, a);
        chk(!mem_we_n && mem_oe_n, "R3 strobe low", {mem_we_n, mem_oe_n}, 2'b01);
        chk(mem_dq_oe == m, "R5 lane drive", mem_dq_oe, m);
        chk((mem_dq_out & lmask(m)) == (d & lmask(m)), "R5 write data", mem_dq_out, d);
        @(negedge clk);
      end
      for (int i = 0; i <= cfg_hold; i++) begin
        check_sel("R3 hold", m, a);
        chk(mem_we_n, "R3 hold strobe high", mem_we_n, 1);
        chk(mem_dq_oe == m, "R5 drive through hold", mem_dq_oe, m);
        @(negedge clk);
      end
      chk(mem_ce_n && !mem_ce, "R3 release at completion", {mem_ce_n, mem_ce}, 2'b10);
      chk(rsp_valid, "R2 completion pulse", rsp_valid, 1);
    end else begin
      for (int i = 0; i <= cfg_access; i++) begin
        check_sel("R6 access", m, a);
        chk(!mem_oe_n && mem_we_n, "R6 read strobes", {mem_oe_n, mem_we_n}, 2'b01);
        chk(mem_dq_oe == 2'b00, "R5 no drive on read", mem_dq_oe, 0);
        @(negedge clk);
      end
      chk(rsp_valid && mem_ce_n, "R6 completion after access", {rsp_valid, mem_ce_n}, 2'b11);
    end
    if (wr) for (int l = 0; l < 2; l++)
      if (m[l]) shadow[a[3:0]][l*8 +: 8] = d[l*8 +: 8];
    @(negedge clk);
    chk(req_ready && !rsp_valid, "R2 ready back, pulse single", {req_ready, rsp_valid}, 2'b10);
    chk(mem_ce_n && mem_dq_oe == 0, "R9 idle deselected", {mem_ce_n, mem_dq_oe}, 3'b100);
  endtask

  task automatic set_cfg(input logic [3:0] s, input logic [3:0] p, input logic [3:0] h, input logic [3:0] r);
    cfg_setup = s; cfg_pulse = p; cfg_hold = h; cfg_access = r;
  endtask

  initial begin
    for (int i = 0; i < 16; i++) begin
      sram[i]   = 16'(i * 16'h0101) ^ 16'h8421;
      shadow[i] = 16'(i * 16'h0101) ^ 16'h8421;
    end
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(mem_ce_n && !mem_ce && mem_oe_n && mem_we_n && mem_lb_n && mem_ub_n,
        "R1 reset pins", {mem_ce_n, mem_ce, mem_oe_n, mem_we_n, mem_lb_n, mem_ub_n}, 6'b101111);
    chk(mem_dq_oe == 0 && req_ready && !rsp_valid, "R1 reset handshake",
        {mem_dq_oe, req_ready, rsp_valid}, 4'b0010);
    rst_n = 1;
    @(negedge clk);

    set_cfg(1, 2, 1, 2);
    do_req(1, 18'd3, 16'hBEEF, 2'b11);
    do_req(0, 18'd3, 16'h0,    2'b11);
    do_req(1, 18'd3, 16'h1234, 2'b01);
    do_req(0, 18'd3, 16'h0,    2'b10);
    do_req(0, 18'd3, 16'h0,    2'b01);
    do_req(1, 18'd3, 16'hFFFF, 2'b00);
    do_req(0, 18'd3, 16'h0,    2'b00);
    do_req(0, 18'd3, 16'h0,    2'b11);

    set_cfg(0, 0, 0, 0);
    do_req(1, 18'd7, 16'hA55A, 2'b10);
    do_req(0, 18'd7, 16'h0,    2'b11);
    do_req(1, 18'h3FFF0, 16'h0F0F, 2'b11);
    do_req(0, 18'h3FFF0, 16'h0,  2'b11);

    set_cfg(3, 0, 2, 0);
    do_req(1, 18'd9, 16'h6C6C, 2'b01);
    do_req(0, 18'd9, 16'h0,    2'b11);
    do_req(0, 18'd12, 16'h0,   2'b10);

    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, "R2 all requests completed", exp_q.size(), 0);
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_fail++;
      $display("FAIL R2 watchdog expired actual=1 expected=0");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule